// File: doc/BRIEF.md
# Bit-Level Two-Wire Serial EEPROM Slave

This block behaves as a 256-byte serial EEPROM on a two-wire bus. It is built for a master that drives the clock and data lines by software, one level change at a time. The block runs in the system clock domain. It takes already synchronized samples of the bus clock line and the bus data line, and it reacts only in system cycles where at least one of the two samples differs from the previous cycle. In those cycles it recognises start and stop conditions, shifts in a command byte and an address byte, answers with acknowledge bits, and, during a read command, shifts stored data out on its data output.

One tick counter covers the whole frame. Ticks 1 to 8 collect the command and ticks 9 to 16 collect the address. The final address bit loads the addressed byte into an output shift register. In a read frame, that byte is sent out while the address of the *next* read frame is being shifted in. The data output register always holds the value the slave last put on the line, so a host can read it back. A separate preload port fills the storage. Write data, page writes and open-drain electrical modelling are not part of this block.

Top module: `twi_rom_slave`

## Requirements
- R1: After a synchronous reset, `sda_out` is 1, the tick counter is 0, no acknowledge is pending, and the stored copies of both lines are 1.
- R2: In a cycle where the inputs change, the bus clock is high both before and after, and the data line falls from the value held on `sda_out` to 0, a start is recognised. The tick counter becomes 1 and the command register is cleared, even in the middle of a frame.
- R3: While the tick counter is 0 and no acknowledge is pending, every input change other than a start leaves the frame state unchanged. `sda_out` then follows `sda_in`.
- R4: A bit is sampled only on a rising bus clock whose data value equals the value held on `sda_out`. When the data line changes together with the rising clock, the bit is dropped and the tick counter does not advance.
- R5: The command is shifted in MSB first over 8 sampled bits. After the 8th bit an acknowledge is pending. On the next rising bus clock, `sda_out` becomes 0, the pending flag clears, and no bit is sampled.
- R6: After the command acknowledge, the next 8 sampled bits shift MSB first into the 8-bit address register.
- R7: When command bit 0 is 1 (read), each address-phase sampled bit sets `sda_out` to the MSB of the data shift register. The data register then shifts left with a 0 filled in.
- R8: The 8th address bit loads the byte at the full new address into the data register, makes an acknowledge pending and returns the tick counter to 0. After that acknowledge, the slave is idle until the next start.
- R9: A rising data line while the bus clock stays high (stop) changes only `sda_out`, which follows the line. The tick counter and the registers keep their values.
- R10: A cycle with `load_en` high writes `load_data` into location `load_addr`. The new value is the one a later address-phase load returns.
- R11: In a cycle where neither `scl_in` nor `sda_in` differs from the previous cycle, the tick counter, the pending acknowledge and `sda_out` keep their values.
- R12: When command bit 0 is 0 (write), `sda_out` follows `sda_in` during the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Synchronized bus clock level |
| sda_in | input | 1 | Synchronized bus data level from the master |
| sda_out | output | 1 | Data level the slave presents (acknowledge, read bits, or the echoed line) |
| load_en | input | 1 | Preload write strobe |
| load_addr | input | ADDR_W | Preload location |
| load_data | input | DATA_W | Preload value |

## Verification
The bench runs whole frames with write commands and with read commands, and uses a different address each time. A write frame echoes the address, which shows the address phase is sampled in order. A read frame returns the byte loaded by the frame before it, which separates "data of the current address" from "data of the previous address" and shows the shift direction. Further patterns insert a bit whose data line changes with the rising clock, a restart part-way through the command, a stop part-way through the command, and a long hold on a high clock after an acknowledge. Because the acknowledge position moves with the number of counted bits, each of these patterns shows whether the counter advanced, was reset, or kept its value.

// File: rtl/twi_rom_pkg.sv
package twi_rom_pkg;

   // Kind of reaction the slave takes in one system cycle.
   typedef enum logic [2:0] {
      STEP_NONE,   // inputs unchanged: nothing happens
      STEP_COND,   // start or stop while clock stays high
      STEP_WAIT,   // idle, waiting for a start
      STEP_ACK,    // rising clock consumes a pending acknowledge
      STEP_CMD,    // rising clock samples a command bit
      STEP_ADR,    // rising clock samples an address bit
      STEP_DROP,   // rising clock with a changing data line
      STEP_PASS    // any other change: line is echoed
   } step_e;

endpackage

// File: rtl/twi_rom_edges.sv
module twi_rom_edges (
   input  logic clk,
   input  logic rst,
   input  logic scl_now,
   input  logic sda_now,
   output logic scl_prev,
   output logic evt
);

   logic sda_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_now;
         sda_prev <= sda_now;
      end
   end

   // A cycle is an event when either line differs from the last sample.
   assign evt = (scl_now != scl_prev) || (sda_now != sda_prev);

endmodule

// File: rtl/twi_rom_store.sv
module twi_rom_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == ADDR_W'(g))) begin
            cell_q <= wr_data;
         end
      end
      assign words[g] = cell_q;
   end

   assign rd_data = words[rd_addr];

endmodule

// File: rtl/twi_rom_seq.sv
module twi_rom_seq
   import twi_rom_pkg::*;
#(
   parameter int CMD_W  = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 evt,
   input  logic                 scl_prev,
   input  logic                 scl_now,
   input  logic                 sda_now,
   input  logic [DATA_W-1:0]    rd_data,
   output logic [ADDR_W-1:0]    rd_addr,
   output logic                 line_o,
   output logic [$clog2(CMD_W+ADDR_W+2)-1:0] tick_o,
   output logic                 ack_o,
   output logic [CMD_W-1:0]     cmd_o,
   output logic                 data_msb_o
);

   localparam int CMD_END = CMD_W + 1;
   localparam int ADR_END = CMD_END + ADDR_W;
   localparam int TICK_W  = $clog2(ADR_END + 1);

   logic [TICK_W-1:0] tick_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              ack_q;
   logic              line_q;

   logic              bus_cond;
   logic              frame_idle;
   logic              scl_rise;
   logic              bit_ok;
   logic [TICK_W-1:0] tick_inc;
   logic [ADDR_W-1:0] addr_nx;
   logic              line_nx;
   step_e             step;

   assign bus_cond   = evt && scl_prev && scl_now && (line_q != sda_now);
   assign frame_idle = (tick_q == '0) && !ack_q;
   assign scl_rise   = evt && !scl_prev && scl_now;
   assign bit_ok     = (line_q == sda_now);
   assign tick_inc   = tick_q + TICK_W'(1);
   assign addr_nx    = {addr_q[ADDR_W-2:0], sda_now};

   // Priority: bus condition, idle wait, non-rising change,
   // pending acknowledge, dropped bit, then the phase of the frame.
   always_comb begin
      if (!evt)                           step = STEP_NONE;
      else if (bus_cond)                  step = STEP_COND;
      else if (frame_idle)                step = STEP_WAIT;
      else if (!scl_rise)                 step = STEP_PASS;
      else if (ack_q)                     step = STEP_ACK;
      else if (!bit_ok)                   step = STEP_DROP;
      else if (tick_q < TICK_W'(CMD_END)) step = STEP_CMD;
      else if (tick_q < TICK_W'(ADR_END)) step = STEP_ADR;
      else                                step = STEP_PASS;
   end

   always_comb begin
      case (step)
         STEP_NONE: line_nx = line_q;
         STEP_ACK:  line_nx = 1'b0;
         STEP_ADR:  line_nx = cmd_q[0] ? data_q[DATA_W-1] : sda_now;
         default:   line_nx = sda_now;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tick_q <= '0;
         cmd_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
         ack_q  <= 1'b0;
         line_q <= 1'b1;
      end else begin
         line_q <= line_nx;
         case (step)
            STEP_COND: begin
               if (!sda_now) begin
                  tick_q <= TICK_W'(1);
                  cmd_q  <= '0;
               end
            end
            STEP_ACK: begin
               ack_q <= 1'b0;
            end
            STEP_CMD: begin
               cmd_q  <= {cmd_q[CMD_W-2:0], sda_now};
               tick_q <= tick_inc;
               if (tick_inc == TICK_W'(CMD_END)) begin
                  ack_q <= 1'b1;
               end
            end
            STEP_ADR: begin
               addr_q <= addr_nx;
               if (tick_inc == TICK_W'(ADR_END)) begin
                  data_q <= rd_data;
                  ack_q  <= 1'b1;
                  tick_q <= '0;
               end else begin
                  data_q <= {data_q[DATA_W-2:0], 1'b0};
                  tick_q <= tick_inc;
               end
            end
            default: begin
            end
         endcase
      end
   end

   assign rd_addr    = addr_nx;
   assign line_o     = line_q;
   assign tick_o     = tick_q;
   assign ack_o      = ack_q;
   assign cmd_o      = cmd_q;
   assign data_msb_o = data_q[DATA_W-1];

endmodule

// File: rtl/twi_rom_slave.sv
module twi_rom_slave #(
   parameter int CMD_W  = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_out,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data
);

   localparam int CMD_END = CMD_W + 1;
   localparam int ADR_END = CMD_END + ADDR_W;
   localparam int TICK_W  = $clog2(ADR_END + 1);

   if (CMD_W < 2) begin : g_bad_cmd
      $error("twi_rom_slave: CMD_W must be at least 2");
   end
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("twi_rom_slave: ADDR_W must lie in 2..12");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("twi_rom_slave: DATA_W must be at least 2");
   end

   logic              evt;
   logic              scl_prev;
   logic [TICK_W-1:0] tick;
   logic              ack_pend;
   logic [CMD_W-1:0]  cmd_q;
   logic              data_msb;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;

   twi_rom_edges u_edges (
      .clk      (clk),
      .rst      (rst),
      .scl_now  (scl_in),
      .sda_now  (sda_in),
      .scl_prev (scl_prev),
      .evt      (evt)
   );

   twi_rom_store #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_store (
      .clk     (clk),
      .wr_en   (load_en),
      .wr_addr (load_addr),
      .wr_data (load_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   twi_rom_seq #(
      .CMD_W  (CMD_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .evt        (evt),
      .scl_prev   (scl_prev),
      .scl_now    (scl_in),
      .sda_now    (sda_in),
      .rd_data    (rd_data),
      .rd_addr    (rd_addr),
      .line_o     (sda_out),
      .tick_o     (tick),
      .ack_o      (ack_pend),
      .cmd_o      (cmd_q),
      .data_msb_o (data_msb)
   );

endmodule

// File: rtl/twi_rom_slave_chk.sv
module twi_rom_slave_chk #(
   parameter int CMD_W  = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  evt,
   input logic                  scl_prev,
   input logic                  scl_now,
   input logic                  sda_now,
   input logic                  sda_line,
   input logic [$clog2(CMD_W+ADDR_W+2)-1:0] tick,
   input logic                  ack,
   input logic [CMD_W-1:0]      cmd,
   input logic                  data_msb
);

   localparam int CMD_END = CMD_W + 1;
   localparam int ADR_END = CMD_END + ADDR_W;
   localparam int TICK_W  = $clog2(ADR_END + 1);

   logic start_seen;
   assign start_seen = evt && scl_prev && scl_now && sda_line && !sda_now;

   // R1: reset leaves an idle slave with a released line
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (tick == '0 && !ack && sda_line));

   // R1: the counter never leaves the frame range
   a_r1_tick_range: assert property (@(posedge clk) disable iff (rst)
      tick < TICK_W'(ADR_END));

   // R2: a start restarts the frame
   a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
      start_seen |=> (tick == TICK_W'(1) && cmd == '0));

   // R3: while idle only a start can leave tick 0
   a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
      (tick == '0 && !ack && !start_seen) |=> (tick == '0 && !ack));

   // R5: a pending acknowledge pulls the line low on the next rising clock
   a_r5_ack_drives_low: assert property (@(posedge clk) disable iff (rst)
      (evt && !scl_prev && scl_now && ack) |=> (!ack && !sda_line));

   // R7: read frames present the data MSB in the address phase
   a_r7_read_bit: assert property (@(posedge clk) disable iff (rst)
      (evt && !scl_prev && scl_now && !ack && tick >= TICK_W'(CMD_END)
       && cmd[0] && (sda_line == sda_now))
      |=> (sda_line == $past(data_msb)));

   // R11: without an input change nothing moves
   a_r11_quiet_hold: assert property (@(posedge clk) disable iff (rst)
      !evt |=> ($stable(tick) && $stable(ack) && $stable(sda_line)));

endmodule

bind twi_rom_slave twi_rom_slave_chk #(
   .CMD_W  (CMD_W),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .evt      (evt),
   .scl_prev (scl_prev),
   .scl_now  (scl_in),
   .sda_now  (sda_in),
   .sda_line (sda_out),
   .tick     (tick),
   .ack      (ack_pend),
   .cmd      (cmd_q),
   .data_msb (data_msb)
);

// File: tb/twi_rom_slave_bench.sv
module twi_rom_slave_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       scl = 1'b1;
   logic       sda = 1'b1;
   logic       load_en = 1'b0;
   logic [7:0] load_addr = '0;
   logic [7:0] load_data = '0;
   logic       sda_out;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_scl = 1, m_line = 1, m_in_scl = 1, m_in_sda = 1;
   int m_tick = 0, m_cmd = 0, m_addr = 0, m_data = 0, m_ack = 0;
   int mem [256];

   always #5 clk = ~clk;

   twi_rom_slave u_twi_rom_slave (
      .clk       (clk),
      .rst       (rst),
      .scl_in    (scl),
      .sda_in    (sda),
      .sda_out   (sda_out),
      .load_en   (load_en),
      .load_addr (load_addr),
      .load_data (load_data)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_step(int s, int d);
      int out;
      if (s == m_in_scl && d == m_in_sda) return;
      out = d;
      if (m_scl == 1 && s == 1 && m_line != d) begin
         if (d == 0) begin m_tick = 1; m_cmd = 0; end
      end else if (m_tick == 0 && m_ack == 0) begin
      end else if (m_scl == 0 && s == 1) begin
         if (m_ack == 1) begin
            out = 0; m_ack = 0;
         end else if (m_line == d) begin
            if (m_tick < 9) begin
               m_cmd = ((m_cmd * 2) + d) % 256;
               m_tick++;
               if (m_tick == 9) m_ack = 1;
            end else begin
               if (m_cmd % 2 == 1) out = (m_data / 128) % 2;
               m_addr = ((m_addr * 2) + d) % 256;
               m_data = (m_data * 2) % 256;
               m_tick++;
               if (m_tick == 17) begin
                  m_data = mem[m_addr]; m_ack = 1; m_tick = 0;
               end
            end
         end
      end
      m_scl = s; m_line = out; m_in_scl = s; m_in_sda = d;
   endtask

   task automatic cmp();
      chk(cur_req, int'(sda_out), m_line);
   endtask

   task automatic drive(int s, int d);
      scl = s[0]; sda = d[0];
      model_step(s, d);
      @(posedge clk); @(negedge clk);
      cmp();
   endtask

   task automatic hold(int n);
      repeat (n) begin @(posedge clk); @(negedge clk); cmp(); end
   endtask

   task automatic send_bit(int b, output int r);
      drive(0, b); drive(1, b); r = int'(sda_out); drive(0, b);
   endtask

   task automatic bus_start();
      drive(1, 1); drive(1, 0); drive(0, 0);
   endtask

   task automatic preload(int a, int v);
      load_en = 1'b1; load_addr = a[7:0]; load_data = v[7:0];
      @(posedge clk); mem[a] = v; @(negedge clk);
      load_en = 1'b0;
   endtask

   task automatic run_frame(int cmd, int adr, output int got,
                            output int ack1, output int ack2);
      int r;
      got = 0;
      bus_start();
      for (int i = 7; i >= 0; i--) send_bit((cmd >> i) % 2, r);
      send_bit(1, ack1);
      for (int i = 7; i >= 0; i--) begin
         send_bit((adr >> i) % 2, r);
         got = got * 2 + r;
      end
      send_bit(1, ack2);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int got, a1, a2, r, bad;
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk("R1", int'(sda_out), 1);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", int'(sda_out), 1);
      for (int i = 0; i < 256; i++) preload(i, i ^ 8'h5A);

      // R3: traffic before any start is echoed, never acknowledged
      cur_req = "R3"; bad = 0;
      for (int i = 8; i >= 0; i--) begin
         send_bit((9'h16B >> i) % 2, r);
         if (r != (9'h16B >> i) % 2) bad++;
      end
      chk("R3", bad, 0);

      // R12 and R5 and R8: write frame echoes the address
      cur_req = "R12";
      run_frame(8'hA0, 8'h3C, got, a1, a2);
      chk("R5", a1, 0); chk("R12", got, 8'h3C); chk("R8", a2, 0);

      // R7 and R6: read frame returns the byte loaded by the frame before
      cur_req = "R7";
      run_frame(8'hA1, 8'h05, got, a1, a2);
      chk("R7", got, 8'h66); chk("R8", a2, 0);

      // R8: after the final acknowledge the slave waits for a start
      cur_req = "R8";
      send_bit(1, r); chk("R8", r, 1);
      send_bit(1, r); chk("R8", r, 1);

      // R10: preload then load the new value
      cur_req = "R10";
      preload(8'h81, 8'hC3);
      run_frame(8'hA1, 8'h81, got, a1, a2);
      chk("R6", got, 8'h5F);
      run_frame(8'hA1, 8'h00, got, a1, a2);
      chk("R10", got, 8'hC3);

      // R4: a bit whose data line moves with the rising clock is dropped
      cur_req = "R4";
      bus_start();
      drive(1, 1); drive(0, 1);
      bad = 0;
      for (int i = 0; i < 8; i++) begin send_bit(1, r); if (r != 1) bad++; end
      chk("R4", bad, 0);
      send_bit(1, r); chk("R4", r, 0);
      got = 0;
      for (int i = 7; i >= 0; i--) begin
         send_bit((8'h10 >> i) % 2, r); got = got * 2 + r;
      end
      chk("R7", got, 8'h5A);
      send_bit(1, r); chk("R8", r, 0);

      // R2: a start in the middle of the command restarts the count
      cur_req = "R2";
      bus_start();
      send_bit(1, r); send_bit(0, r); send_bit(1, r);
      run_frame(8'hA0, 8'h22, got, a1, a2);
      chk("R2", a1, 0); chk("R2", got, 8'h22);

      // R9: a stop keeps the count (its rising clock samples a 0 bit)
      cur_req = "R9";
      bus_start();
      for (int i = 0; i < 3; i++) send_bit(1, r);
      drive(0, 0); drive(1, 0); drive(1, 1);
      chk("R9", int'(sda_out), 1);
      bad = 0;
      for (int i = 0; i < 4; i++) begin send_bit(1, r); if (r != 1) bad++; end
      chk("R9", bad, 0);
      send_bit(1, r); chk("R9", r, 0);
      for (int i = 0; i < 8; i++) send_bit(0, r);
      send_bit(1, r); chk("R8", r, 0);

      // R11: a long high clock after an acknowledge keeps the line low
      cur_req = "R11";
      bus_start();
      for (int i = 7; i >= 0; i--) send_bit((8'hA0 >> i) % 2, r);
      drive(0, 1); drive(1, 1);
      chk("R5", int'(sda_out), 0);
      hold(5);
      chk("R11", int'(sda_out), 0);
      drive(0, 1);
      for (int i = 0; i < 8; i++) send_bit(1, r);
      send_bit(1, r); chk("R8", r, 0);
      hold(3);

      summary();
      $finish;
   end

endmodule